// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block holds the floating-point status and control word next to an FP execution unit. Each time the unit completes an operation it pulses a completion strobe and presents five condition bits: invalid operation, divide-by-zero, overflow, underflow and inexact. The register keeps three 5-bit fields for these conditions:

- a cause field that shows only what the latest operation raised;
- an enable mask written by software;
- a sticky flags field that collects every condition seen since software last cleared it.

When the current operation raises a condition whose enable bit is set, the block asserts an exception request in that same cycle. With the enable bit clear, no request is made, and the datapath substitutes its default result.

The word also carries a 2-bit rounding-mode field, which goes straight to the datapath. Software reads the whole word on one port. It writes the word through per-field write strobes, so it can update one field without disturbing the others. A software write in the same cycle as a completion wins for every field the write selects.

Top module: `fp_status_ctl`

## Requirements
- R1: After reset, all four fields read as zero and the rounding-mode output is 0.
- R2: On every cycle with `done` high and no cause write, the cause field (`rd_data[16:12]`) becomes exactly `cond`, including all zeros.
- R3: On every cycle with `done` high and no flags write, each flags bit (`rd_data[6:2]`) becomes its old value ORed with the matching `cond` bit. A set flag stays set until software writes it.
- R4: `exc_req` is high in exactly those cycles where `done` is high and `cond` shares a set bit with the enable field as it stood before that cycle's clock edge. It is combinational and lasts one cycle per strobe.
- R5: A condition whose enable bit is 0 never raises `exc_req`. The condition still sets its cause and flags bits.
- R6: `wr_fld[2]` loads the enable field (`rd_data[11:7]`) from the matching bits of `wr_data`. Field strobes are: bit 3 cause, bit 2 enables, bit 1 flags, bit 0 rounding mode.
- R7: When a software write and `done` occur in the same cycle, each written field takes the software value. Fields that are not written still follow R2 and R3.
- R8: `wr_fld[0]` loads the rounding field (`rd_data[1:0]`), which also drives `rnd_mode`. The encoding is 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf.
- R9: With `done` low and no write strobe, the register is unchanged, whatever `cond` holds.
- R10: In every 5-bit field and in `cond`, bit 4 is invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow and bit 0 inexact. `cond` bit k maps to bit k of each field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_fld | input | 4 | Per-field write strobes (cause, enables, flags, rounding) |
| wr_data | input | 17 | Software write data, same layout as `rd_data` |
| done | input | 1 | FP operation completion strobe |
| cond | input | 5 | Conditions raised by the completing operation |
| rd_data | output | 17 | Register contents {cause, enables, flags, rounding} |
| exc_req | output | 1 | Exception request, same cycle as `done` |
| rnd_mode | output | 2 | Current rounding mode |

## Verification
The bench pairs a completion with a write in the same cycle in several forms, so that the write clearly wins for the selected fields while the unselected fields still update. A design with the priority reversed would keep stale flags, or would lose the conditions in the fields that were not written.

It also changes the enable mask in the same cycle as a completion. This shows that the request uses the mask already in force: a design that forwarded the new mask would raise a spurious trap. A completion with no conditions must clear cause while the flags keep their set bits, which catches a cause field built as a sticky field. Finally, a garbage `cond` with no strobe must leave the register untouched.

// File: rtl/fp_status_ctl.sv
module fp_status_ctl #(
  parameter int NCOND = 5,
  parameter int RMW   = 2,
  localparam int REGW = 3*NCOND + RMW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       wr_fld,
  input  logic [REGW-1:0]  wr_data,
  input  logic             done,
  input  logic [NCOND-1:0] cond,
  output logic [REGW-1:0]  rd_data,
  output logic             exc_req,
  output logic [RMW-1:0]   rnd_mode
);

  localparam int RM_LO = 0;
  localparam int FL_LO = RMW;
  localparam int EN_LO = RMW + NCOND;
  localparam int CA_LO = RMW + 2*NCOND;

  logic [NCOND-1:0] cause_q, en_q, flags_q;
  logic [RMW-1:0]   rm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      en_q    <= '0;
      flags_q <= '0;
      rm_q    <= '0;
    end else begin
      if (wr_fld[3])  cause_q <= wr_data[CA_LO +: NCOND];
      else if (done)  cause_q <= cond;
      if (wr_fld[2])  en_q    <= wr_data[EN_LO +: NCOND];
      if (wr_fld[1])  flags_q <= wr_data[FL_LO +: NCOND];
      else if (done)  flags_q <= flags_q | cond;
      if (wr_fld[0])  rm_q    <= wr_data[RM_LO +: RMW];
    end
  end

  assign exc_req  = done & |(cond & en_q);
  assign rd_data  = {cause_q, en_q, flags_q, rm_q};
  assign rnd_mode = rm_q;

  // R2
  cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_fld[3]) |=> (rd_data[CA_LO +: NCOND] == $past(cond)));

  // R3
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_fld[1]) |=> ((rd_data[FL_LO +: NCOND] & $past(cond)) == $past(cond)));

  // R4
  req_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> done);

  // R5
  masked_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_data[EN_LO +: NCOND] == '0) |-> !exc_req);

  // R7
  flags_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fld[1] |=> (rd_data[FL_LO +: NCOND] == $past(wr_data[FL_LO +: NCOND])));

  // R8
  rm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fld[0] |=> (rnd_mode == $past(wr_data[RM_LO +: RMW])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && wr_fld == 4'b0) |=> $stable(rd_data));

endmodule

// File: tb/fp_status_ctl_tb.sv
`timescale 1ns/100ps
module fp_status_ctl_tb;
  localparam int W = 17;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] wr_fld = '0;
  logic [W-1:0] wr_data = '0;
  logic done = 1'b0;
  logic [4:0] cond = '0;
  logic [W-1:0] rd_data;
  logic exc_req;
  logic [1:0] rnd_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_status_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_fld(wr_fld), .wr_data(wr_data),
    .done(done), .cond(cond), .rd_data(rd_data), .exc_req(exc_req),
    .rnd_mode(rnd_mode)
  );

  function automatic logic [W-1:0] pk(logic [4:0] c, logic [4:0] e, logic [4:0] f, logic [1:0] r);
    return {c, e, f, r};
  endfunction

  // {wr_fld, wr_data, done, cond, exp_exc, exp_rd}
  localparam logic [44:0] VEC [NV] = '{
    {4'b0000, pk(0,0,0,0), 1'b1, 5'b10000, 1'b0, pk(5'b10000, 5'b00000, 5'b10000, 2'd0)},
    {4'b0000, pk(0,0,0,0), 1'b1, 5'b00000, 1'b0, pk(5'b00000, 5'b00000, 5'b10000, 2'd0)},
    {4'b0100, pk(0,5'b00110,0,0), 1'b0, 5'b00000, 1'b0, pk(5'b00000, 5'b00110, 5'b10000, 2'd0)},
    {4'b0000, pk(0,0,0,0), 1'b1, 5'b00001, 1'b0, pk(5'b00001, 5'b00110, 5'b10001, 2'd0)},
    {4'b0000, pk(0,0,0,0), 1'b1, 5'b00100, 1'b1, pk(5'b00100, 5'b00110, 5'b10101, 2'd0)},
    {4'b0000, pk(0,0,0,0), 1'b0, 5'b11111, 1'b0, pk(5'b00100, 5'b00110, 5'b10101, 2'd0)},
    {4'b0010, pk(0,0,0,0), 1'b1, 5'b01000, 1'b0, pk(5'b01000, 5'b00110, 5'b00000, 2'd0)},
    {4'b0001, pk(0,0,0,2'd2), 1'b0, 5'b00000, 1'b0, pk(5'b01000, 5'b00110, 5'b00000, 2'd2)},
    {4'b1000, pk(5'b00011,0,0,0), 1'b1, 5'b00010, 1'b1, pk(5'b00011, 5'b00110, 5'b00010, 2'd2)},
    {4'b0100, pk(0,5'b11111,0,0), 1'b1, 5'b10000, 1'b0, pk(5'b10000, 5'b11111, 5'b10010, 2'd2)},
    {4'b0000, pk(0,0,0,0), 1'b1, 5'b01000, 1'b1, pk(5'b01000, 5'b11111, 5'b11010, 2'd2)},
    {4'b1111, pk(0,0,0,2'd3), 1'b1, 5'b11111, 1'b1, pk(5'b00000, 5'b00000, 5'b00000, 2'd3)},
    {4'b0000, pk(0,0,0,0), 1'b1, 5'b11111, 1'b0, pk(5'b11111, 5'b00000, 5'b11111, 2'd3)}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic step(input logic [3:0] f, input logic [W-1:0] d, input logic dn,
                      input logic [4:0] c, input logic ex, input logic [W-1:0] er);
    wr_fld = f; wr_data = d; done = dn; cond = c;
    #1;
    chk("R4 exc_req", int'(exc_req), int'(ex));
    @(posedge clk);
    @(negedge clk);
    wr_fld = '0; wr_data = '0; done = 1'b0; cond = '0;
    chk("R2 cause", int'(rd_data[16:12]), int'(er[16:12]));
    chk("R6 enables", int'(rd_data[11:7]), int'(er[11:7]));
    chk("R3 flags", int'(rd_data[6:2]), int'(er[6:2]));
    chk("R8 rnd_mode", int'(rnd_mode), int'(er[1:0]));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset rnd_mode", int'(rnd_mode), 0);
    rst_n = 1'b1;
    // R5 R7 R9 R10 exercised across vectors 4, 7, 9, 10, 6
    for (int i = 0; i < NV; i++)
      step(VEC[i][44:41], VEC[i][40:24], VEC[i][23], VEC[i][22:18], VEC[i][17], VEC[i][16:0]);

    // R3: empty completion clears cause, flags stay
    step(4'b0000, '0, 1'b1, 5'b00000, 1'b0, pk(5'b00000, 5'b00000, 5'b11111, 2'd3));
    // R8: other encodings
    step(4'b0001, pk(0,0,0,2'd1), 1'b0, 5'b00000, 1'b0, pk(5'b00000, 5'b00000, 5'b11111, 2'd1));
    step(4'b0001, pk(0,0,0,2'd0), 1'b0, 5'b00000, 1'b0, pk(5'b00000, 5'b00000, 5'b11111, 2'd0));
    // R10: single-bit invalid enable, only invalid traps
    step(4'b0100, pk(0,5'b10000,0,0), 1'b0, 5'b00000, 1'b0, pk(5'b00000, 5'b10000, 5'b11111, 2'd0));
    step(4'b0000, '0, 1'b1, 5'b01111, 1'b0, pk(5'b01111, 5'b10000, 5'b11111, 2'd0));
    step(4'b0000, '0, 1'b1, 5'b10000, 1'b1, pk(5'b10000, 5'b10000, 5'b11111, 2'd0));

    // R1: reset mid-run
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid reset rd_data", int'(rd_data), 0);
    chk("R1 mid reset rnd_mode", int'(rnd_mode), 0);
    rst_n = 1'b1;
    done = 1'b1; cond = 5'b11111;
    #1;
    chk("R1 enables cleared no trap", int'(exc_req), 0);
    @(negedge clk);
    done = 1'b0; cond = '0;

    finished = 1;
    report();
  end
endmodule